// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command pins from reset until the memory is ready for ordinary traffic. After reset is released it enables the clock (CKE), then keeps the device deselected for a settling interval of at least 200 microseconds. The number of cycles in that interval comes from a clock-frequency parameter. It then closes every bank with one precharge-all command. Next it issues a parameterised number of auto-refresh commands, never fewer than eight. The last command is a mode-register load that places the externally supplied mode word on the address and bank pins. At no point does it read or write the memory array.

Each command is followed by enough deselect cycles to meet a minimum command-to-command spacing: T_RP after precharge, T_RFC after each refresh and T_MRD after the mode load. All three are cycle-count parameters. When the last spacing has elapsed, `init_done` rises and stays high until the next reset. The main controller takes over the bus from then on.

The control is one FSM with the states WAIT_POWER, PRECHARGE, WAIT_RP, REFRESH, WAIT_RFC, LOAD_MODE, WAIT_MRD and DONE. A single down-counter is shared by every wait. The transitions are:
- WAIT_POWER to PRECHARGE when the settle count reaches zero.
- PRECHARGE to WAIT_RP, which loads T_RP-2.
- WAIT_RP to REFRESH on zero.
- REFRESH to WAIT_RFC, which loads T_RFC-2 and counts the refresh.
- WAIT_RFC back to REFRESH on zero while refreshes remain, or to LOAD_MODE on zero once all have been issued.
- LOAD_MODE to WAIT_MRD, which loads T_MRD-2.
- WAIT_MRD to DONE on zero.
- DONE holds until reset.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low, `cke` and `init_done` are low, `cs_n`, `ras_n`, `cas_n` and `we_n` are high, and `addr` and `ba` are zero.
- R2: Call the first cycle after reset release cycle 0. In cycle 0 `cke` is low. From cycle 1 it is high and stays high until reset. Cycles 0 through S are deselected, where S = CLK_MHZ*SETTLE_US. A SETTLE_US below 200 is rejected at elaboration.
- R3: In cycle S+1 a precharge-all is issued. Its encoding is {cs_n,ras_n,cas_n,we_n} = 0010, with `addr` bit 10 high, every other `addr` bit zero, and `ba` zero.
- R4: Exactly REFRESH_COUNT auto-refresh commands (encoding 0001, address and bank zero) are issued. The first comes T_RP cycles after the precharge, and each later one comes T_RFC cycles after the one before. A REFRESH_COUNT below 8 is rejected at elaboration.
- R5: A mode-register load (encoding 0000) is issued T_RFC cycles after the last refresh. It drives `addr` = `mode_addr` and `ba` = `mode_bank` as present in that cycle. The mode inputs have no effect in any other cycle.
- R6: `cs_n` is low only in the single cycle of each command. Every other cycle has `cs_n`, `ras_n`, `cas_n` and `we_n` all high, with `addr` and `ba` zero.
- R7: No read or write command is ever driven. Whenever `cs_n` is low, `ras_n` is low too.
- R8: `init_done` rises exactly T_MRD cycles after the mode-register load and stays high until reset, with the bus deselected. A T_RP, T_RFC or T_MRD below 2 is rejected at elaboration.
- R9: Asserting reset at any point of the sequence abandons it. After release the sequence restarts from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_addr | input | ADDR_W | Mode word driven on the address pins during the mode load |
| mode_bank | input | BANK_W | Bank bits driven during the mode load |
| cke | output | 1 | Clock enable to the SDRAM |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address pins |
| ba | output | BANK_W | Bank address pins |
| init_done | output | 1 | High once initialization has finished |

## Verification
The bench runs three sequences.
- The first is a complete sequence with a sparse mode word. It shows that the commands come in order and that the spacing is exact rather than merely long enough.
- The second is reset in the middle of the settling interval and then run to completion. It separates a clean restart from a counter or refresh tally left over from the aborted run.
- The third uses a dense mode word and changes the mode inputs both before and after the load. Only the value present in the load cycle may reach the pins, so this shows whether the design samples the mode word at the right moment.

Each sequence is also decoded into a timeline of commands. That timeline shows whether the refresh count and the gap lengths follow the parameters.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        WAIT_POWER,
        PRECHARGE,
        WAIT_RP,
        REFRESH,
        WAIT_RFC,
        LOAD_MODE,
        WAIT_MRD,
        DONE
    } init_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_DESEL = 4'b1111,
        CMD_PRE   = 4'b0010,
        CMD_REF   = 4'b0001,
        CMD_MRS   = 4'b0000
    } sdram_cmd_t;

endpackage

// File: rtl/init_gap_counter.sv
module init_gap_counter #(
    parameter int W       = 16,
    parameter int RST_VAL = 100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/init_cmd_encoder.sv
module init_cmd_encoder
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2,
    parameter int AP_BIT = 10
) (
    input  sdram_cmd_t        cmd,
    input  logic [ADDR_W-1:0] mode_addr,
    input  logic [BANK_W-1:0] mode_bank,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba
);
    always_comb begin
        {cs_n, ras_n, cas_n, we_n} = cmd;
        addr = '0;
        ba   = '0;
        unique case (cmd)
            CMD_PRE: addr[AP_BIT] = 1'b1;
            CMD_MRS: begin
                addr = mode_addr;
                ba   = mode_bank;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int BANK_W        = 2,
    parameter int CLK_MHZ       = 100,
    parameter int SETTLE_US     = 200,
    parameter int REFRESH_COUNT = 8,
    parameter int T_RP          = 3,
    parameter int T_RFC         = 7,
    parameter int T_MRD         = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mode_addr,
    input  logic [BANK_W-1:0] mode_bank,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba,
    output logic              init_done
);
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
    localparam int GAP_MAX    = (T_RP > T_RFC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                               : ((T_RFC > T_MRD) ? T_RFC : T_MRD);
    localparam int CNT_MAX    = (SETTLE_CYC > GAP_MAX) ? SETTLE_CYC : GAP_MAX;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam int REF_W      = $clog2(REFRESH_COUNT + 1);

    generate
        if (SETTLE_US < 200) begin : g_bad_settle
            $error("settling interval must be at least 200 us");
        end
        if (REFRESH_COUNT < 8) begin : g_bad_refresh
            $error("at least 8 refresh commands are required");
        end
        if (T_RP < 2 || T_RFC < 2 || T_MRD < 2) begin : g_bad_gap
            $error("command spacing parameters must be at least 2");
        end
        if (ADDR_W < 11) begin : g_bad_addr
            $error("address must include the auto-precharge bit");
        end
    endgenerate

    init_state_t      state_q, state_d;
    logic [REF_W-1:0] ref_cnt_q;
    logic             cke_q;
    logic             gap_load;
    logic [CNT_W-1:0] gap_val;
    logic             gap_zero;
    sdram_cmd_t       cmd;

    init_gap_counter #(
        .W       (CNT_W),
        .RST_VAL (SETTLE_CYC)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .zero     (gap_zero)
    );

    // next state and counter loads
    always_comb begin
        state_d  = state_q;
        gap_load = 1'b0;
        gap_val  = '0;
        unique case (state_q)
            WAIT_POWER: if (gap_zero) state_d = PRECHARGE;
            PRECHARGE: begin
                state_d  = WAIT_RP;
                gap_load = 1'b1;
                gap_val  = CNT_W'(T_RP - 2);
            end
            WAIT_RP: if (gap_zero) state_d = REFRESH;
            REFRESH: begin
                state_d  = WAIT_RFC;
                gap_load = 1'b1;
                gap_val  = CNT_W'(T_RFC - 2);
            end
            WAIT_RFC: begin
                if (gap_zero) begin
                    state_d = (ref_cnt_q == REF_W'(REFRESH_COUNT)) ? LOAD_MODE : REFRESH;
                end
            end
            LOAD_MODE: begin
                state_d  = WAIT_MRD;
                gap_load = 1'b1;
                gap_val  = CNT_W'(T_MRD - 2);
            end
            WAIT_MRD: if (gap_zero) state_d = DONE;
            DONE:     state_d = DONE;
            default:  state_d = WAIT_POWER;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= WAIT_POWER;
            ref_cnt_q <= '0;
            cke_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            cke_q   <= 1'b1;
            if (state_q == REFRESH) ref_cnt_q <= ref_cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        cmd       = CMD_DESEL;
        init_done = 1'b0;
        unique case (state_q)
            PRECHARGE: cmd = CMD_PRE;
            REFRESH:   cmd = CMD_REF;
            LOAD_MODE: cmd = CMD_MRS;
            DONE:      init_done = 1'b1;
            default:   cmd = CMD_DESEL;
        endcase
    end

    assign cke = cke_q;

    init_cmd_encoder #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .AP_BIT (10)
    ) u_enc (
        .cmd       (cmd),
        .mode_addr (mode_addr),
        .mode_bank (mode_bank),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .ba        (ba)
    );
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
    parameter int ADDR_W        = 13,
    parameter int BANK_W        = 2,
    parameter int SETTLE_CYC    = 20000,
    parameter int REFRESH_COUNT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BANK_W-1:0] ba,
    input logic              init_done
);
    logic is_pre, is_ref, is_mrs;
    int   cke_hi_cnt;
    int   ref_seen;

    assign is_pre = !cs_n && !ras_n &&  cas_n && !we_n;
    assign is_ref = !cs_n && !ras_n && !cas_n &&  we_n;
    assign is_mrs = !cs_n && !ras_n && !cas_n && !we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cke_hi_cnt <= 0;
            ref_seen   <= 0;
        end else begin
            if (cke && cke_hi_cnt < SETTLE_CYC) cke_hi_cnt <= cke_hi_cnt + 1;
            if (is_ref) ref_seen <= ref_seen + 1;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |-> (!cke && cs_n && !init_done));

    a_r2_settle_before_pre: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (cke_hi_cnt >= SETTLE_CYC));

    a_r2_cke_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    a_r3_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (addr[10] && ba == '0));

    a_r4_refresh_count: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (ref_seen == REFRESH_COUNT));

    a_r6_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (ras_n && cas_n && we_n));

    a_r7_no_read_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !ras_n);

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r8_done_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> cs_n);
endmodule

bind sdram_init_seq sdram_init_chk #(
    .ADDR_W        (ADDR_W),
    .BANK_W        (BANK_W),
    .SETTLE_CYC    (CLK_MHZ * SETTLE_US),
    .REFRESH_COUNT (REFRESH_COUNT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .ba        (ba),
    .init_done (init_done)
);

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 13;
    localparam int BANK_W = 2;
    localparam int CLK_MHZ = 10;
    localparam int SETTLE_US = 200;
    localparam int NREF = 9;
    localparam int TRP = 3;
    localparam int TRFC = 6;
    localparam int TMRD = 2;
    localparam int S = CLK_MHZ * SETTLE_US;
    localparam int K_PRE = S + 1;
    localparam int K_REF0 = K_PRE + TRP;
    localparam int K_MRS = K_REF0 + NREF * TRFC;
    localparam int K_DONE = K_MRS + TMRD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] mode_addr = '0;
    logic [BANK_W-1:0] mode_bank = '0;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [ADDR_W-1:0] addr;
    logic [BANK_W-1:0] ba;

    int checks = 0;
    int fails = 0;
    int k_pre, k_mrs, k_done, n_ref;
    int ref_k[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_init_seq #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US),
        .REFRESH_COUNT(NREF), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .mode_addr(mode_addr), .mode_bank(mode_bank),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ba(ba), .init_done(init_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_reset_state();
        check(cke == 1'b0 && init_done == 1'b0, "R1", "cke/done in reset",
              {cke, init_done}, 0);
        check({cs_n, ras_n, cas_n, we_n} == 4'b1111 && addr == '0 && ba == '0,
              "R1", "pins in reset", {cs_n, ras_n, cas_n, we_n, addr, ba}, {4'b1111, 15'h0});
    endtask

    // behavioural reference for cycle k after reset release
    task automatic compare_cycle(input int k);
        logic [3:0] e_cmd;
        logic [ADDR_W-1:0] e_addr;
        logic [BANK_W-1:0] e_ba;
        string tag;
        e_cmd = 4'b1111; e_addr = '0; e_ba = '0;
        if (k < K_PRE) tag = "R2";
        else if (k >= K_DONE) tag = "R8";
        else tag = "R6";
        if (k == K_PRE) begin
            e_cmd = 4'b0010; e_addr = ADDR_W'(1) << 10; tag = "R3";
        end else if (k >= K_REF0 && k < K_MRS && ((k - K_REF0) % TRFC) == 0) begin
            e_cmd = 4'b0001; tag = "R4";
        end else if (k == K_MRS) begin
            e_cmd = 4'b0000; e_addr = mode_addr; e_ba = mode_bank; tag = "R5";
        end
        check({cs_n, ras_n, cas_n, we_n} == e_cmd, tag, "command",
              {cs_n, ras_n, cas_n, we_n}, e_cmd);
        check(addr == e_addr && ba == e_ba, tag, "addr/bank", {ba, addr}, {e_ba, e_addr});
        check(cke == (k >= 1), "R2", "cke", cke, (k >= 1));
        check(init_done == (k >= K_DONE), "R8", "init_done", init_done, (k >= K_DONE));
        check(cs_n || !ras_n, "R7", "no read/write", {cs_n, ras_n}, 2'b10);
        // decoded timeline
        if ({cs_n, ras_n, cas_n, we_n} == 4'b0010) k_pre = k;
        if ({cs_n, ras_n, cas_n, we_n} == 4'b0001) begin n_ref++; ref_k.push_back(k); end
        if ({cs_n, ras_n, cas_n, we_n} == 4'b0000) k_mrs = k;
        if (init_done && k_done < 0) k_done = k;
    endtask

    // release reset and follow the sequence for ncyc cycles; hook changes mode inputs
    task automatic run_seq(input int ncyc, input logic [ADDR_W-1:0] ma1,
                           input logic [BANK_W-1:0] mb1, input logic [ADDR_W-1:0] ma2,
                           input logic [BANK_W-1:0] mb2, input bit full);
        k_pre = -1; k_mrs = -1; k_done = -1; n_ref = 0;
        ref_k.delete();
        mode_addr = ma1; mode_bank = mb1;
        rst_n = 1'b1;
        for (int k = 0; k < ncyc; k++) begin
            if (k == K_MRS) begin mode_addr = ma2; mode_bank = mb2; end
            if (k == K_MRS + 1) begin mode_addr = ~ma2; mode_bank = ~mb2; end
            #1;
            compare_cycle(k);
            @(negedge clk);
        end
        if (full) begin
            check(n_ref == NREF, "R4", "refresh count", n_ref, NREF);
            check(k_pre == K_PRE, "R3", "precharge cycle", k_pre, K_PRE);
            if (ref_k.size() > 0)
                check(ref_k[0] - k_pre == TRP, "R4", "precharge-to-refresh gap",
                      ref_k[0] - k_pre, TRP);
            for (int i = 1; i < ref_k.size(); i++)
                check(ref_k[i] - ref_k[i-1] == TRFC, "R4", "refresh gap",
                      ref_k[i] - ref_k[i-1], TRFC);
            if (ref_k.size() > 0)
                check(k_mrs - ref_k[ref_k.size()-1] == TRFC, "R5", "refresh-to-mode gap",
                      k_mrs - ref_k[ref_k.size()-1], TRFC);
            check(k_done - k_mrs == TMRD, "R8", "mode-to-done gap", k_done - k_mrs, TMRD);
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        #1;
        check_reset_state();
        repeat (3) @(negedge clk);
        check_reset_state();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired (all requirements)");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        check_reset_state();
        repeat (2) @(negedge clk);
        check_reset_state();

        // sparse mode word, full sequence plus idle tail
        run_seq(K_DONE + 30, 13'h0033, 2'd0, 13'h0033, 2'd0, 1'b1);

        // reset during the settling interval, then complete run (R9)
        apply_reset();
        run_seq(700, 13'h0000, 2'd0, 13'h0000, 2'd0, 1'b0);
        apply_reset();
        run_seq(K_DONE + 10, 13'h0222, 2'd1, 13'h0222, 2'd1, 1'b1);
        check(n_ref == NREF, "R9", "refresh count after restart", n_ref, NREF);

        // dense mode word; inputs change before and after the load cycle
        apply_reset();
        run_seq(K_DONE + 20, 13'h1555, 2'd2, 13'h1AAA, 2'd3, 1'b1);

        apply_reset();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule